// File: doc/BRIEF.md
# Multicycle Integer Processor Core

This block is a small non-pipelined 32-bit integer processor. Every instruction passes through a fixed series of states chosen by its class: fetch, decode with register read, execute or address calculation, memory access or branch completion, and write-back. Between states every intermediate value is kept in its own named register: the instruction word, the sequential next PC, the two source operands, the extended immediate, the execute result, the branch condition and the loaded word.

The core has a single memory port for both instructions and data. The port takes a word address, write data and a write strobe, and returns read data one clock after the address is presented. An instruction word therefore arrives during decode, and a loaded word arrives during write-back. Both are registered there. The register file has 32 entries, and entry 0 is fixed at zero.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, PC is 0, the memory port addresses word 0 and the write strobe is low.
- R2: Each instruction is fetched from word address PC/4. The next instruction is fetched right after the last state of the current one, so the fetch of the second instruction comes 4 cycles after the first fetch when the first is an ALU operation.
- R3: Opcode 0 with func 0x20, 0x22, 0x24, 0x25 or 0x26 writes rs+rt, rs-rt, rs&rt, rs|rt or rs^rt into rd and takes 4 cycles.
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate into rt and takes 4 cycles.
- R5: Opcode 0x23 loads the memory word at rs plus the sign-extended immediate into rt and takes 5 cycles.
- R6: Opcode 0x2B writes rt to word address (rs+immediate)/4 in the fourth cycle of the instruction and takes 4 cycles. The write strobe is never raised for any other instruction.
- R7: Opcode 0x04 branches when rs is zero, and opcode 0x05 branches when rs is non-zero. The target is PC+4 plus the sign-extended immediate shifted left by 2. When the condition fails, execution continues at PC+4. Both cases take 4 cycles.
- R8: Opcode 0x02 jumps to PC+4 plus the sign-extended 26-bit offset shifted left by 2, and takes 4 cycles.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode, or opcode 0 with any other func, is a no-op that returns to fetch after decode. It takes 2 cycles and continues at PC+4.
- R11: The instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], func [5:0], immediate [15:0] and jump offset [25:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rdata | input | 32 | Read data for the address presented one cycle earlier |
| mem_addr | output | ADDR_W | Word address for the memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for the memory port |

## Verification
Only stores leave the core, so every register result has to be routed through a store before the bench can see it. The timing of each store also carries the cycle counts of all instructions before it. The hardest cases to reach are a branch that must not be taken and a jump that skips a store, because a correct design shows no event at all for them. The stimulus places a store in each shadow, so that a wrong redirect appears as an extra store. A short countdown loop with a backward branch, a no-op opcode and a write to register 0 are also placed between observable stores, so each one changes either a stored value or the cycle in which a later store appears.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 32;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;
  localparam logic [5:0] OPC_BZ   = 6'h04;
  localparam logic [5:0] OPC_BNZ  = 6'h05;
  localparam logic [5:0] OPC_JMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEMORY, ST_WRITE
  } state_t;

  typedef enum logic [2:0] {
    CL_RR, CL_ADDI, CL_LOAD, CL_STORE, CL_BRZ, CL_BRNZ, CL_JUMP, CL_NONE
  } iclass_t;

  function automatic iclass_t classify(input logic [WORD_W-1:0] w);
    iclass_t c;
    case (w[31:26])
      OPC_RR: begin
        case (w[5:0])
          FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR: c = CL_RR;
          default:                               c = CL_NONE;
        endcase
      end
      OPC_ADDI: c = CL_ADDI;
      OPC_LW:   c = CL_LOAD;
      OPC_SW:   c = CL_STORE;
      OPC_BZ:   c = CL_BRZ;
      OPC_BNZ:  c = CL_BRNZ;
      OPC_JMP:  c = CL_JUMP;
      default:  c = CL_NONE;
    endcase
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
    return {{(WORD_W-16){v[15]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] sext26(input logic [25:0] v);
    return {{(WORD_W-26){v[25]}}, v};
  endfunction

  function automatic logic [WORD_W-1:0] rr_result(input logic [5:0] fn,
                                                  input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
    case (fn)
      FN_ADD:  return a + b;
      FN_SUB:  return a - b;
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_XOR:  return a ^ b;
      default: return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] rel_target(input logic [WORD_W-1:0] npc,
                                                   input logic [WORD_W-1:0] words);
    return npc + (words << 2);
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] ra_a,
  input  logic [RIDX-1:0] ra_b,
  output logic [W-1:0]    rd_a,
  output logic [W-1:0]    rd_b,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [W-1:0]    wd
);
  logic [W-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar gi = 1; gi < NREG; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                             regs[gi] <= '0;
      else if (we && wa == RIDX'(gi))         regs[gi] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_a == '0) |-> (rd_a == '0)); // R9
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_b == '0) |-> (rd_b == '0)); // R9
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
(
  input  iclass_t            cls,
  input  logic [WORD_W-1:0]  instr,
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  input  logic [WORD_W-1:0]  imm,
  input  logic [WORD_W-1:0]  npc,
  output logic [WORD_W-1:0]  result,
  output logic               take
);
  always_comb begin
    result = '0;
    take   = 1'b0;
    case (cls)
      CL_RR:                       result = rr_result(instr[5:0], a, b);
      CL_ADDI, CL_LOAD, CL_STORE:  result = a + imm;
      CL_BRZ: begin
        result = rel_target(npc, imm);
        take   = (a == '0);
      end
      CL_BRNZ: begin
        result = rel_target(npc, imm);
        take   = (a != '0);
      end
      CL_JUMP: begin
        result = rel_target(npc, sext26(instr[25:0]));
        take   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t cls,
  output state_t  state
);
  state_t nxt;

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: nxt = (cls == CL_NONE) ? ST_FETCH : ST_EXEC;
      ST_EXEC:   nxt = (cls == CL_RR || cls == CL_ADDI) ? ST_WRITE : ST_MEMORY;
      ST_MEMORY: nxt = (cls == CL_LOAD) ? ST_WRITE : ST_FETCH;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (state == ST_DECODE)); // R2
  AST_WRITE_ENDS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE) |=> (state == ST_FETCH)); // R3
  AST_NOOP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && cls == CL_NONE) |=> (state == ST_FETCH)); // R10
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_we
);
  localparam int RIDX = $clog2(NUM_REGS);

  state_t            state;
  iclass_t           cls;
  logic [WORD_W-1:0] pc, npc, ir, a_q, b_q, imm_q, alu_q, lmd_q;
  logic              take_q;
  logic [WORD_W-1:0] live, rf_a, rf_b, alu_res, wb_data;
  logic              alu_take, rf_we, is_branch;
  logic [RIDX-1:0]   wb_idx;

  // Instruction word arrives on the port during decode; later states use IR.
  assign live      = (state == ST_DECODE) ? mem_rdata : ir;
  assign cls       = classify(live);
  assign is_branch = (cls == CL_BRZ) || (cls == CL_BRNZ) || (cls == CL_JUMP);

  mc_ctrl u_ctrl (.clk(clk), .rst_n(rst_n), .cls(cls), .state(state));

  assign rf_we   = (state == ST_WRITE);
  assign wb_idx  = (cls == CL_RR) ? ir[15:11] : ir[20:16];
  assign wb_data = (cls == CL_LOAD) ? mem_rdata : alu_q;

  mc_regfile #(.NREG(NUM_REGS), .W(WORD_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(live[25:21]), .ra_b(live[20:16]),
    .rd_a(rf_a), .rd_b(rf_b),
    .we(rf_we), .wa(wb_idx), .wd(wb_data)
  );

  mc_alu u_alu (
    .cls(cls), .instr(ir), .a(a_q), .b(b_q), .imm(imm_q), .npc(npc),
    .result(alu_res), .take(alu_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; npc <= '0; ir <= '0; a_q <= '0; b_q <= '0;
      imm_q <= '0; alu_q <= '0; lmd_q <= '0; take_q <= 1'b0;
    end else begin
      case (state)
        ST_FETCH:  npc <= pc + 32'd4;
        ST_DECODE: begin
          ir    <= mem_rdata;
          a_q   <= rf_a;
          b_q   <= rf_b;
          imm_q <= sext16(mem_rdata[15:0]);
          pc    <= npc;
        end
        ST_EXEC: begin
          alu_q  <= alu_res;
          take_q <= alu_take;
        end
        ST_MEMORY: if (is_branch && take_q) pc <= alu_q;
        ST_WRITE:  if (cls == CL_LOAD) lmd_q <= mem_rdata;
        default: ;
      endcase
    end
  end

  assign mem_addr  = (state == ST_MEMORY) ? alu_q[ADDR_W+1:2] : pc[ADDR_W+1:2];
  assign mem_wdata = b_q;
  assign mem_we    = (state == ST_MEMORY) && (cls == CL_STORE);

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R2
  AST_STORE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state) == ST_EXEC)); // R6
  AST_UNTAKEN_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MEMORY && is_branch && !take_q) |=> (pc == $past(npc))); // R7
  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE) |-> (npc == pc + 32'd4)); // R2
endmodule

// File: tb/tb_mc_core.sv
module tb_mc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_we;

  always #2 clk = ~clk;

  mc_core dut (.clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata),
               .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we));

  logic [31:0] ram [0:255];
  logic [31:0] mdl [0:255];
  string       tag_at [0:255];

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [15:0] q_addr [$];
  logic [31:0] q_data [$];
  int          q_cyc  [$];
  string       q_tag  [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] e_r(input logic [5:0] fn, input logic [4:0] rd,
                                      input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction
  function automatic logic [31:0] e_i(input logic [5:0] op, input logic [4:0] rt,
                                      input logic [4:0] rs, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  task automatic put(input int idx, input logic [31:0] w, input string tg);
    ram[idx] = w; mdl[idx] = w; tag_at[idx] = tg;
  endtask

  // Driver: an instruction-level model walks the program and queues the
  // stores it predicts, each with the cycle its memory state falls in.
  int t_end = 0;
  task automatic run_model();
    logic [31:0] r [0:31];
    logic [31:0] pc = 0;
    int t = 0;
    for (int i = 0; i < 32; i++) r[i] = 0;
    for (int step = 0; step < 400; step++) begin
      logic [31:0] w, s, ea, tgt;
      logic [4:0]  rs, rt, rd;
      bit stop;
      stop = 0;
      w  = mdl[pc[9:2]];
      rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
      s  = {{16{w[15]}}, w[15:0]};
      case (w[31:26])
        6'h00: begin
          case (w[5:0])
            6'h20: begin r[rd] = r[rs] + r[rt]; t += 4; end
            6'h22: begin r[rd] = r[rs] - r[rt]; t += 4; end
            6'h24: begin r[rd] = r[rs] & r[rt]; t += 4; end
            6'h25: begin r[rd] = r[rs] | r[rt]; t += 4; end
            6'h26: begin r[rd] = r[rs] ^ r[rt]; t += 4; end
            default: t += 2;
          endcase
          pc += 4;
        end
        6'h08: begin r[rt] = r[rs] + s; t += 4; pc += 4; end
        6'h23: begin ea = r[rs] + s; r[rt] = mdl[ea[9:2]]; t += 5; pc += 4; end
        6'h2B: begin
          ea = r[rs] + s;
          q_addr.push_back(ea[17:2]); q_data.push_back(r[rt]);
          q_cyc.push_back(t + 3);     q_tag.push_back(tag_at[pc[9:2]]);
          mdl[ea[9:2]] = r[rt];
          t += 4; pc += 4;
        end
        6'h04, 6'h05: begin
          t += 4;
          if ((w[31:26] == 6'h04) == (r[rs] == 0)) pc = pc + 4 + (s << 2);
          else                                     pc = pc + 4;
        end
        6'h02: begin
          tgt = pc + 4 + ({{6{w[25]}}, w[25:0]} << 2);
          if (tgt == pc) stop = 1;
          t += 4; pc = tgt;
        end
        default: begin t += 2; pc += 4; end
      endcase
      r[0] = 0;
      if (stop) break;
    end
    t_end = t;
  endtask

  // Monitor: compares each store on the port with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && mem_we && !done) begin
      if (q_addr.size() == 0) begin
        check(0, "R6/R7/R8", "unexpected store addr", {48'h0, mem_addr}, 64'h0);
      end else begin
        logic [15:0] ea; logic [31:0] ed; int ec; string et;
        ea = q_addr.pop_front(); ed = q_data.pop_front();
        ec = q_cyc.pop_front();  et = q_tag.pop_front();
        check(mem_addr == ea && mem_wdata == ed && cyc == ec, et,
              $sformatf("store @cycle %0d addr %0h", cyc, mem_addr),
              {mem_addr, 16'h0, mem_wdata}, {ea, 16'h0, ed});
        if (cyc != ec)
          $display("  (store cycle actual %0d expected %0d)", cyc, ec);
      end
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = 0; mdl[i] = 0; tag_at[i] = "R6"; end
    ram[63] = 32'hA5A5_5A5A; mdl[63] = 32'hA5A5_5A5A;
    put(0,  e_i(6'h08, 5'd1, 5'd0, 16'd256), "R4");
    put(1,  e_i(6'h08, 5'd2, 5'd0, 16'd5), "R4");
    put(2,  e_i(6'h08, 5'd3, 5'd0, 16'hFFFD), "R4");
    put(3,  e_i(6'h2B, 5'd3, 5'd1, 16'd0), "R4 negative immediate");
    put(4,  e_r(6'h20, 5'd4, 5'd2, 5'd3), "R3");
    put(5,  e_i(6'h2B, 5'd4, 5'd1, 16'd4), "R3 add");
    put(6,  e_r(6'h22, 5'd5, 5'd2, 5'd3), "R3");
    put(7,  e_i(6'h2B, 5'd5, 5'd1, 16'd8), "R3 sub");
    put(8,  e_r(6'h24, 5'd6, 5'd2, 5'd3), "R3");
    put(9,  e_i(6'h2B, 5'd6, 5'd1, 16'd12), "R3 and");
    put(10, e_r(6'h25, 5'd7, 5'd2, 5'd3), "R3");
    put(11, e_i(6'h2B, 5'd7, 5'd1, 16'd16), "R3 or");
    put(12, e_r(6'h26, 5'd8, 5'd2, 5'd3), "R3");
    put(13, e_i(6'h2B, 5'd8, 5'd1, 16'd20), "R3 xor R11");
    put(14, e_i(6'h08, 5'd0, 5'd0, 16'd7), "R9");
    put(15, e_i(6'h2B, 5'd0, 5'd1, 16'd24), "R9 zero register");
    put(16, 32'hFC00_0000, "R10");
    put(17, e_i(6'h2B, 5'd2, 5'd1, 16'd28), "R10 undefined opcode timing");
    put(18, e_i(6'h23, 5'd9, 5'd1, 16'd4), "R5");
    put(19, e_i(6'h2B, 5'd9, 5'd1, 16'd32), "R5 load");
    put(20, e_i(6'h23, 5'd10, 5'd1, 16'hFFFC), "R5");
    put(21, e_i(6'h2B, 5'd10, 5'd1, 16'd36), "R5 load negative offset");
    put(22, e_i(6'h08, 5'd11, 5'd0, 16'd3), "R7");
    put(23, e_i(6'h08, 5'd11, 5'd11, 16'hFFFF), "R7");
    put(24, e_i(6'h2B, 5'd11, 5'd1, 16'd40), "R7 backward branch loop");
    put(25, e_i(6'h05, 5'd0, 5'd11, 16'hFFFD), "R7");
    put(26, e_i(6'h04, 5'd0, 5'd11, 16'd1), "R7");
    put(27, e_i(6'h2B, 5'd2, 5'd1, 16'd44), "R7 shadow of taken branch");
    put(28, e_i(6'h04, 5'd0, 5'd2, 16'd1), "R7");
    put(29, e_i(6'h2B, 5'd2, 5'd1, 16'd48), "R7 untaken branch");
    put(30, {6'h02, 26'd1}, "R8");
    put(31, e_i(6'h2B, 5'd2, 5'd1, 16'd52), "R8 shadow of jump");
    put(32, e_i(6'h2B, 5'd1, 5'd1, 16'd56), "R8 jump target");
    put(33, e_r(6'h3F, 5'd12, 5'd2, 5'd2), "R10");
    put(34, {6'h02, 26'h3FF_FFFF}, "R8");
    run_model();

    repeat (3) @(posedge clk);
    // R1: state while reset is held
    @(negedge clk);
    check(mem_addr == 0 && mem_we == 0, "R1", "port during reset",
          {47'h0, mem_we, mem_addr}, 64'h0);
    rst_n = 1'b1;
    #1;
    check(mem_addr == 0 && mem_we == 0 && cyc == 0, "R1", "first fetch after reset",
          {47'h0, mem_we, mem_addr}, 64'h0);
    while (cyc != 4) @(negedge clk);
    check(mem_addr == 16'd1, "R2", "second fetch address at cycle 4",
          {48'h0, mem_addr}, 64'd1);
    while (cyc < t_end + 20) @(negedge clk);
    check(q_addr.size() == 0, "R6", "stores still pending",
          64'(q_addr.size()), 64'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule